// File: doc/BRIEF.md
# Two-Output Routed Interrupt Controller

This block gathers 224 interrupt request lines, arranged as seven 32-bit words, and steers each line to one of two level outputs, `irq_ext0` and `irq_ext1`. For each line software sets four things: the trigger kind (level or edge), which level or edge is active, which output the line drives, and whether the line is enabled. Edge-triggered lines latch a pending bit that software clears by writing ones. Level-triggered lines show their present state with no latching.

The inputs are asynchronous and pass through a synchronizer chain (two stages by default) before any decision is made. Software reaches the block through a plain word-addressed register bus with two windows. The configuration window holds the four per-line settings as four runs of seven words. The status window holds the clear words, a masked pending view for each output, and one summary word that shows which words hold a live request for each output. A service routine reads the summary word, then the matching status word, then clears the line.

Top module: `rintc_top`

## Requirements
- R1: After reset, the type words read all ones (edge), the polarity words read 0, the routing words read all ones (output 0), the mask words read 0, the summary word reads 0 and both outputs are low.
- R2: In the configuration window (bus_win=0), word addresses 0-6 hold type, 7-13 polarity, 14-20 routing and 21-27 mask, one word per group of 32 lines, with line n at word n/32, bit n%32. Each word reads back the last value written to it.
- R3: A level line (type bit 0) is pending while its synchronized input equals 1 (polarity 0) or 0 (polarity 1). The pending bit drops when the input returns to idle and is not cleared by a clear write. A change at the input shows at the outputs two rising clock edges later.
- R4: An edge line (type bit 1) latches pending on a rising edge of its synchronized input (polarity 0) or on a falling edge (polarity 1). It stays set after the input returns and shows at the outputs three rising clock edges after the input changes. A change of the polarity bit alone never sets it.
- R5: Writing to status-window (bus_win=1) word addresses 0-6 clears the edge pending bits where the written data is 1. Bits written 0 keep their state. The clear takes effect at the write edge.
- R6: If a clear write and a newly detected edge reach the same line in the same cycle, the pending bit ends up set.
- R7: A line with mask bit 0 drives neither output nor any status or summary bit, but its latched edge stays pending. Setting the mask bit later exposes it at once.
- R8: A line with routing bit 1 appears in status words 14-20 and on irq_ext0. A line with routing bit 0 appears in status words 7-13 and on irq_ext1. Changing the routing bit moves a pending line between outputs at the write edge.
- R9: The summary word, at status address 31, has bit w set when status word w for irq_ext1 is nonzero (bits 6:0) and bit 8+w set when status word w for irq_ext0 is nonzero (bits 14:8). All other bits read 0.
- R10: irq_ext0 is high exactly when some enabled pending line routed to it exists, and irq_ext1 likewise.
- R11: bus_rdata is loaded at the rising edge where bus_rd is high and holds its value otherwise. The clear words and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 224 | Raw interrupt request lines |
| bus_win | input | 1 | Window select: 0 configuration, 1 status |
| bus_addr | input | 5 | Word address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_ext0 | output | 1 | Level request for lines routed to output 0 |
| irq_ext1 | output | 1 | Level request for lines routed to output 1 |

## Verification
A level line reaches an output two rising edges after its input moves. An edge line needs a third edge to latch. Configuration and clear writes act at the edge that takes the write, and read data appears one edge after the read strobe. The bench drives and samples on falling edges. At each stimulus it checks the output one edge before the result is due and again at the edge it is due. The same-cycle clear-and-edge case is set up by counting edges so that the write lands exactly in the cycle the edge is detected.

// File: rtl/rintc_pkg.sv
`timescale 1ns/1ps
package rintc_pkg;
   typedef enum logic {
      WIN_CFG  = 1'b0,
      WIN_STAT = 1'b1
   } win_e;

   // word groups inside each window, in address order
   typedef enum int {
      GRP_TYPE  = 0,
      GRP_POL   = 1,
      GRP_ROUTE = 2,
      GRP_MASK  = 3
   } cfg_grp_e;

   typedef enum int {
      GRP_CLR  = 0,
      GRP_ST1  = 1,
      GRP_ST0  = 2
   } stat_grp_e;
endpackage

// File: rtl/rintc_src_word.sv
`timescale 1ns/1ps
module rintc_src_word #(
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] irq_raw,
   input  logic [WORD_W-1:0] typ,
   input  logic [WORD_W-1:0] pol,
   input  logic [WORD_W-1:0] clr,
   output logic [WORD_W-1:0] pend,
   output logic [WORD_W-1:0] evt,
   output logic [WORD_W-1:0] edge_pend
);
   logic [WORD_W-1:0] smp;
   logic [WORD_W-1:0] prev_q;
   logic [WORD_W-1:0] lat_q;
   logic [WORD_W-1:0] rise;
   logic [WORD_W-1:0] fall;
   logic [WORD_W-1:0] lvl;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("rintc_src_word: SYNC_STAGES must lie in 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign smp = irq_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][WORD_W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q <= '0;
         end else begin
            stg_q[0] <= irq_raw;
            for (int k = 1; k < SYNC_STAGES; k++) begin
               stg_q[k] <= stg_q[k-1];
            end
         end
      end
      assign smp = stg_q[SYNC_STAGES-1];
   end

   // edges are taken on the raw sampled value so a polarity write is never an event
   assign rise = smp & ~prev_q;
   assign fall = ~smp & prev_q;
   assign evt  = typ & ((rise & ~pol) | (fall & pol));
   assign lvl  = smp ^ pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         lat_q  <= '0;
      end else begin
         prev_q <= smp;
         // new event has priority over a clear in the same cycle
         lat_q  <= ((lat_q & ~clr) | evt) & typ;
      end
   end

   assign edge_pend = lat_q;
   assign pend      = (typ & lat_q) | (~typ & lvl);
endmodule

// File: rtl/rintc_regs.sv
`timescale 1ns/1ps
module rintc_regs
   import rintc_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 7,
   parameter int ADDR_W    = 5,
   parameter int SUM_ADDR  = 31
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_win,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic                              bus_rd,
   input  logic [WORD_W-1:0]                 bus_wdata,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  st0,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  st1,
   input  logic [WORD_W-1:0]                 summary,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  type_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  pol_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  route_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  mask_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  clr,
   output logic [WORD_W-1:0]                 bus_rdata
);
   localparam int TYPE_BASE  = int'(GRP_TYPE)  * NUM_WORDS;
   localparam int POL_BASE   = int'(GRP_POL)   * NUM_WORDS;
   localparam int ROUTE_BASE = int'(GRP_ROUTE) * NUM_WORDS;
   localparam int MASK_BASE  = int'(GRP_MASK)  * NUM_WORDS;
   localparam int CLR_BASE   = int'(GRP_CLR)   * NUM_WORDS;
   localparam int ST1_BASE   = int'(GRP_ST1)   * NUM_WORDS;
   localparam int ST0_BASE   = int'(GRP_ST0)   * NUM_WORDS;

   logic cfg_wr;
   logic stat_wr;
   logic [WORD_W-1:0] rd_mux;

   assign cfg_wr  = bus_wr && (bus_win == WIN_CFG);
   assign stat_wr = bus_wr && (bus_win == WIN_STAT);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] typ_r, pol_r, rte_r, msk_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            typ_r <= '1;
            pol_r <= '0;
            rte_r <= '1;
            msk_r <= '0;
         end else if (cfg_wr) begin
            if (bus_addr == ADDR_W'(TYPE_BASE + w))  typ_r <= bus_wdata;
            if (bus_addr == ADDR_W'(POL_BASE + w))   pol_r <= bus_wdata;
            if (bus_addr == ADDR_W'(ROUTE_BASE + w)) rte_r <= bus_wdata;
            if (bus_addr == ADDR_W'(MASK_BASE + w))  msk_r <= bus_wdata;
         end
      end
      assign type_q[w]  = typ_r;
      assign pol_q[w]   = pol_r;
      assign route_q[w] = rte_r;
      assign mask_q[w]  = msk_r;
      assign clr[w] = (stat_wr && bus_addr == ADDR_W'(CLR_BASE + w)) ? bus_wdata : '0;
   end

   always_comb begin
      rd_mux = '0;
      if (bus_win == WIN_CFG) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(TYPE_BASE + w))  rd_mux = type_q[w];
            if (bus_addr == ADDR_W'(POL_BASE + w))   rd_mux = pol_q[w];
            if (bus_addr == ADDR_W'(ROUTE_BASE + w)) rd_mux = route_q[w];
            if (bus_addr == ADDR_W'(MASK_BASE + w))  rd_mux = mask_q[w];
         end
      end else begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(ST1_BASE + w)) rd_mux = st1[w];
            if (bus_addr == ADDR_W'(ST0_BASE + w)) rd_mux = st0[w];
         end
         if (bus_addr == ADDR_W'(SUM_ADDR)) rd_mux = summary;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/rintc_top.sv
`timescale 1ns/1ps
module rintc_top #(
   parameter int WORD_W       = 32,
   parameter int NUM_WORDS    = 7,
   parameter int ADDR_W       = 5,
   parameter int SUM_ADDR     = 31,
   parameter int SUM_EXT0_LSB = 8,
   parameter int SYNC_STAGES  = 2,
   localparam int NUM_SRC     = WORD_W * NUM_WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic               bus_win,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   output logic               irq_ext0,
   output logic               irq_ext1
);
   if (NUM_WORDS < 1 || NUM_WORDS > SUM_EXT0_LSB) begin : g_bad_words
      $error("rintc_top: NUM_WORDS must fit below the output-0 summary field");
   end
   if (SUM_EXT0_LSB + NUM_WORDS > WORD_W) begin : g_bad_sum
      $error("rintc_top: summary fields exceed the word width");
   end
   if (4 * NUM_WORDS > SUM_ADDR || SUM_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("rintc_top: register map does not fit the address space");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] type_q, pol_q, route_q, mask_q, clr;
   logic [NUM_WORDS-1:0][WORD_W-1:0] pend, evt, edge_pend;
   logic [NUM_WORDS-1:0][WORD_W-1:0] live, st0, st1;
   logic [WORD_W-1:0]                summary;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_src
      rintc_src_word #(
         .WORD_W      (WORD_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .irq_raw   (irq_src[w*WORD_W +: WORD_W]),
         .typ       (type_q[w]),
         .pol       (pol_q[w]),
         .clr       (clr[w]),
         .pend      (pend[w]),
         .evt       (evt[w]),
         .edge_pend (edge_pend[w])
      );
   end

   assign live = pend & mask_q;
   assign st0  = live & route_q;
   assign st1  = live & ~route_q;

   always_comb begin
      summary = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         summary[w]                = |st1[w];
         summary[SUM_EXT0_LSB + w] = |st0[w];
      end
   end

   assign irq_ext0 = |st0;
   assign irq_ext1 = |st1;

   rintc_regs #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W),
      .SUM_ADDR  (SUM_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_win   (bus_win),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .st0       (st0),
      .st1       (st1),
      .summary   (summary),
      .type_q    (type_q),
      .pol_q     (pol_q),
      .route_q   (route_q),
      .mask_q    (mask_q),
      .clr       (clr),
      .bus_rdata (bus_rdata)
   );
endmodule

// File: rtl/rintc_chk.sv
`timescale 1ns/1ps
module rintc_chk #(
   parameter int WORD_W       = 32,
   parameter int NUM_WORDS    = 7,
   parameter int SUM_EXT0_LSB = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] type_q,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] route_q,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] pend,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] evt,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] edge_pend,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] clr,
   input logic [WORD_W-1:0]                summary,
   input logic                             irq_ext0,
   input logic                             irq_ext1,
   input logic                             bus_rd,
   input logic [WORD_W-1:0]                bus_rdata
);
   // latched edges survive unless cleared or retyped
   assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(edge_pend & type_q & ~clr) & type_q & ~edge_pend) == '0));

   assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr & ~evt) & edge_pend) == '0));

   assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt) & type_q & ~edge_pend) == '0));

   assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> (!irq_ext0 && !irq_ext1));

   assert_route0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext0 |-> ((pend & mask_q & route_q) != '0));

   assert_route1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext1 |-> ((pend & mask_q & ~route_q) != '0));

   assert_sum_out0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext0 == (summary[SUM_EXT0_LSB +: NUM_WORDS] != '0));

   assert_sum_out1_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext1 == (summary[NUM_WORDS-1:0] != '0));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind rintc_top rintc_chk #(
   .WORD_W       (WORD_W),
   .NUM_WORDS    (NUM_WORDS),
   .SUM_EXT0_LSB (SUM_EXT0_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .type_q    (type_q),
   .route_q   (route_q),
   .mask_q    (mask_q),
   .pend      (pend),
   .evt       (evt),
   .edge_pend (edge_pend),
   .clr       (clr),
   .summary   (summary),
   .irq_ext0  (irq_ext0),
   .irq_ext1  (irq_ext1),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata)
);

// File: tb/sim_rintc_top.sv
`timescale 1ns/1ps
module sim_rintc_top;
   localparam int NSRC = 224;
   // window 0 bases
   localparam logic [4:0] A_TYPE = 5'd0, A_POL = 5'd7, A_ROUTE = 5'd14, A_MASK = 5'd21;
   // window 1 bases
   localparam logic [4:0] A_CLR = 5'd0, A_ST1 = 5'd7, A_ST0 = 5'd14, A_SUM = 5'd31;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] irq_src = '0;
   logic            bus_win = 1'b0;
   logic [4:0]      bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_ext0, irq_ext1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rintc_top u0 (
      .clk (clk), .rst_n (rst_n), .irq_src (irq_src),
      .bus_win (bus_win), .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .irq_ext0 (irq_ext0), .irq_ext1 (irq_ext1)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic win, input logic [4:0] addr, input logic [31:0] data);
      bus_win = win; bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic win, input logic [4:0] addr, output logic [31:0] data);
      bus_win = win; bus_addr = addr; bus_rd = 1'b1;
      step();
      bus_rd = 1'b0;
      data = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 out0", {31'b0, irq_ext0}, 32'd0);
      chk("R1 out1", {31'b0, irq_ext1}, 32'd0);
      rd(1'b0, A_TYPE + 5'd0, d);  chk("R1 type w0", d, 32'hFFFF_FFFF);
      rd(1'b0, A_TYPE + 5'd6, d);  chk("R1 type w6", d, 32'hFFFF_FFFF);
      rd(1'b0, A_POL + 5'd3, d);   chk("R1 pol w3", d, 32'h0);
      rd(1'b0, A_ROUTE + 5'd5, d); chk("R1 route w5", d, 32'hFFFF_FFFF);
      rd(1'b0, A_MASK + 5'd0, d);  chk("R1 mask w0", d, 32'h0);
      rd(1'b1, A_SUM, d);          chk("R1 summary", d, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(1'b0, A_TYPE + 5'd1, 32'h1234_5678);
      wr(1'b0, A_POL + 5'd3, 32'hA5A5_0F0F);
      wr(1'b0, A_ROUTE + 5'd2, 32'h0000_FFFF);
      wr(1'b0, A_MASK + 5'd5, 32'h8000_0001);
      rd(1'b0, A_TYPE + 5'd1, d);  chk("R2 type w1", d, 32'h1234_5678);
      rd(1'b0, A_POL + 5'd3, d);   chk("R2 pol w3", d, 32'hA5A5_0F0F);
      rd(1'b0, A_ROUTE + 5'd2, d); chk("R2 route w2", d, 32'h0000_FFFF);
      rd(1'b0, A_MASK + 5'd5, d);  chk("R2 mask w5", d, 32'h8000_0001);
      rd(1'b0, A_TYPE + 5'd2, d);  chk("R2 neighbour untouched", d, 32'hFFFF_FFFF);
      rd(1'b1, A_CLR + 5'd1, d);   chk("R11 clear word reads 0", d, 32'h0);
      rd(1'b1, 5'd25, d);          chk("R11 unused reads 0", d, 32'h0);
      wr(1'b0, A_TYPE + 5'd1, 32'hFFFF_FFFF);
      wr(1'b0, A_POL + 5'd3, 32'h0);
      wr(1'b0, A_ROUTE + 5'd2, 32'hFFFF_FFFF);
      wr(1'b0, A_MASK + 5'd5, 32'h0);
   endtask

   // lines 5 and 6, rising edge, output 0
   task automatic t_edge_rise();
      logic [31:0] d;
      wr(1'b0, A_MASK + 5'd0, 32'h0000_0060);
      irq_src[5] = 1'b1; irq_src[6] = 1'b1;
      step(); chk("R4 not after 1 edge", {31'b0, irq_ext0}, 32'd0);
      step(); chk("R4 not after 2 edges", {31'b0, irq_ext0}, 32'd0);
      step(); chk("R4 set after 3 edges", {31'b0, irq_ext0}, 32'd1);
      irq_src[5] = 1'b0; irq_src[6] = 1'b0;
      repeat (4) step();
      chk("R4 latched after input drops", {31'b0, irq_ext0}, 32'd1);
      chk("R10 out1 idle", {31'b0, irq_ext1}, 32'd0);
      rd(1'b1, A_ST0 + 5'd0, d); chk("R8 status out0 w0", d, 32'h0000_0060);
      rd(1'b1, A_ST1 + 5'd0, d); chk("R8 status out1 w0", d, 32'h0);
      rd(1'b1, A_SUM, d);        chk("R9 summary out0 w0", d, 32'h0000_0100);
      wr(1'b1, A_CLR + 5'd0, 32'h0000_0020);
      rd(1'b1, A_ST0 + 5'd0, d); chk("R5 selective clear", d, 32'h0000_0040);
      wr(1'b1, A_CLR + 5'd0, 32'h0000_0040);
      chk("R5 cleared at write edge", {31'b0, irq_ext0}, 32'd0);
      wr(1'b0, A_MASK + 5'd0, 32'h0);
   endtask

   // line 223, falling edge, output 1
   task automatic t_edge_fall();
      logic [31:0] d;
      wr(1'b0, A_POL + 5'd6, 32'h8000_0000);
      wr(1'b0, A_ROUTE + 5'd6, 32'h7FFF_FFFF);
      wr(1'b0, A_MASK + 5'd6, 32'h8000_0000);
      repeat (3) step();
      chk("R4 polarity write is no event", {31'b0, irq_ext1}, 32'd0);
      irq_src[223] = 1'b1;
      repeat (4) step();
      chk("R4 rising ignored when falling", {31'b0, irq_ext1}, 32'd0);
      irq_src[223] = 1'b0;
      step(); step();
      chk("R4 fall not after 2 edges", {31'b0, irq_ext1}, 32'd0);
      step();
      chk("R4 fall set after 3 edges", {31'b0, irq_ext1}, 32'd1);
      chk("R10 out0 idle", {31'b0, irq_ext0}, 32'd0);
      rd(1'b1, A_ST1 + 5'd6, d); chk("R8 status out1 w6", d, 32'h8000_0000);
      rd(1'b1, A_SUM, d);        chk("R9 summary out1 w6", d, 32'h0000_0040);
      wr(1'b1, A_CLR + 5'd6, 32'h8000_0000);
      chk("R5 clear out1", {31'b0, irq_ext1}, 32'd0);
      wr(1'b0, A_POL + 5'd6, 32'h0);
      wr(1'b0, A_ROUTE + 5'd6, 32'hFFFF_FFFF);
      wr(1'b0, A_MASK + 5'd6, 32'h0);
   endtask

   // line 40 (word 1 bit 8), level
   task automatic t_level();
      wr(1'b0, A_TYPE + 5'd1, 32'hFFFF_FEFF);
      wr(1'b0, A_MASK + 5'd1, 32'h0000_0100);
      chk("R3 idle low", {31'b0, irq_ext0}, 32'd0);
      irq_src[40] = 1'b1;
      step(); chk("R3 not after 1 edge", {31'b0, irq_ext0}, 32'd0);
      step(); chk("R3 high after 2 edges", {31'b0, irq_ext0}, 32'd1);
      irq_src[40] = 1'b0;
      step(); chk("R3 still high 1 edge", {31'b0, irq_ext0}, 32'd1);
      step(); chk("R3 follows input, no latch", {31'b0, irq_ext0}, 32'd0);
      wr(1'b0, A_POL + 5'd1, 32'h0000_0100);
      chk("R3 active low at write edge", {31'b0, irq_ext0}, 32'd1);
      wr(1'b1, A_CLR + 5'd1, 32'h0000_0100);
      chk("R3 clear has no effect on level", {31'b0, irq_ext0}, 32'd1);
      irq_src[40] = 1'b1;
      step(); step();
      chk("R3 active low released", {31'b0, irq_ext0}, 32'd0);
      irq_src[40] = 1'b0;
      wr(1'b0, A_MASK + 5'd1, 32'h0);
      wr(1'b0, A_POL + 5'd1, 32'h0);
      wr(1'b0, A_TYPE + 5'd1, 32'hFFFF_FFFF);
   endtask

   // line 70 (word 2 bit 6): mask and routing
   task automatic t_mask_route();
      logic [31:0] d;
      irq_src[70] = 1'b1;
      repeat (4) step();
      chk("R7 masked out0", {31'b0, irq_ext0}, 32'd0);
      rd(1'b1, A_ST0 + 5'd2, d); chk("R7 masked status", d, 32'h0);
      rd(1'b1, A_SUM, d);        chk("R7 masked summary", d, 32'h0);
      wr(1'b0, A_MASK + 5'd2, 32'h0000_0040);
      chk("R7 unmask exposes latched edge", {31'b0, irq_ext0}, 32'd1);
      rd(1'b1, A_ST0 + 5'd2, d); chk("R7 status after unmask", d, 32'h0000_0040);
      wr(1'b0, A_ROUTE + 5'd2, 32'hFFFF_FFBF);
      chk("R8 reroute out1 high", {31'b0, irq_ext1}, 32'd1);
      chk("R8 reroute out0 low", {31'b0, irq_ext0}, 32'd0);
      rd(1'b1, A_ST1 + 5'd2, d); chk("R8 status out1 w2", d, 32'h0000_0040);
      rd(1'b1, A_SUM, d);        chk("R9 summary out1 w2", d, 32'h0000_0004);
      wr(1'b1, A_CLR + 5'd2, 32'h0000_0040);
      chk("R10 out1 low after clear", {31'b0, irq_ext1}, 32'd0);
      irq_src[70] = 1'b0;
      wr(1'b0, A_ROUTE + 5'd2, 32'hFFFF_FFFF);
      wr(1'b0, A_MASK + 5'd2, 32'h0);
   endtask

   // line 5: clear lands in the cycle the new edge is detected
   task automatic t_collide();
      wr(1'b0, A_MASK + 5'd0, 32'h0000_0020);
      irq_src[5] = 1'b1;
      repeat (3) step();
      irq_src[5] = 1'b0;
      repeat (3) step();
      chk("R6 pending before collision", {31'b0, irq_ext0}, 32'd1);
      irq_src[5] = 1'b1;
      step(); step();
      wr(1'b1, A_CLR + 5'd0, 32'h0000_0020);
      chk("R6 edge wins over clear", {31'b0, irq_ext0}, 32'd1);
      wr(1'b1, A_CLR + 5'd0, 32'h0000_0020);
      chk("R5 plain clear after collision", {31'b0, irq_ext0}, 32'd0);
      irq_src[5] = 1'b0;
      wr(1'b0, A_MASK + 5'd0, 32'h0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_regs();
      t_edge_rise();
      t_edge_fall();
      t_level();
      t_mask_route();
      t_collide();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule